// File: doc/BRIEF.md
# ATM Cell Header Assembler

This block builds the five-octet header of an outgoing constant-bit-rate ATM cell from per-channel configuration fields. The fields are the flow-control nibble, the path and channel identifiers, the payload type, the loss priority bit, a programmed header-check octet and a user-defined extra octet. A single start strobe captures every field and mode bit. The header then streams out over a valid/ready handshake, either one octet per beat or two octets per beat.

Three per-cell mode bits shape the output. The first picks the user-network layout, which carries a 4-bit flow-control field, or the network-network layout, which widens the path identifier to 12 bits. The second picks an 8-bit or a 16-bit cell interface. Only the 16-bit interface carries the extra user-defined octet, which shares the last word with the header check. The third picks the header check: either the programmed placeholder, for when the physical layer computes the check itself, or a CRC-8 that the block computes.

Top module: `atm_hdr_asm`

## Requirements
- R1: After reset, and after any reset asserted during a cell, `out_valid` and `out_last` are 0.
- R2: With `nni_mode`=0, octet 1 is {`gfc[3:0]`,`vpi[7:4]`} and octet 2 is {`vpi[3:0]`,`vci[15:12]`}; `vpi[11:8]` has no effect.
- R3: With `nni_mode`=1, octet 1 is `vpi[11:4]` and octet 2 is {`vpi[3:0]`,`vci[15:12]`}; `gfc` has no effect.
- R4: Octet 3 is `vci[11:4]`; octet 4 is {`vci[3:0]`,`pti[2:0]`,`clp`}, with `clp` in bit 0.
- R5: With `hec_calc`=1, the header-check octet is the remainder of octets 1 to 4, taken MSB first, divided modulo 2 by x^8+x^2+x+1, then XORed with 0x55 (header 00 00 00 01 gives 0x52).
- R6: With `hec_calc`=0, the header-check octet equals `hec_prog`.
- R7: With `wide_mode`=0, five beats carry octet 1, octet 2, octet 3, octet 4 and the check octet on `out_data[7:0]`, with `out_data[15:8]`=0; `udf2` never appears.
- R8: With `wide_mode`=1, three beats carry {octet1,octet2}, {octet3,octet4} and {check,`udf2`}, the earlier octet in `out_data[15:8]`.
- R9: `out_valid` rises in the cycle after a start accepted while idle. A beat stays unchanged while `out_ready` is low, and the block advances only on an edge where both `out_valid` and `out_ready` are high.
- R10: `out_last` is 1 only on the final beat. After that beat is taken, `out_valid` falls.
- R11: Fields are captured at the accepted start, so later changes to them have no effect on the cell in flight. A start while `out_valid` is 1 is ignored and begins no new cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture fields and begin a header |
| nni_mode | input | 1 | 1 = network-network layout |
| wide_mode | input | 1 | 1 = 16-bit beats with extra octet |
| hec_calc | input | 1 | 1 = computed check, 0 = placeholder |
| gfc | input | 4 | Flow-control nibble (user-network only) |
| vpi | input | 12 | Path identifier |
| vci | input | 16 | Channel identifier |
| pti | input | 3 | Payload type |
| clp | input | 1 | Loss priority |
| hec_prog | input | 8 | Programmed check placeholder |
| udf2 | input | 8 | User-defined octet for 16-bit mode |
| out_data | output | 16 | Header beat |
| out_valid | output | 1 | Beat present |
| out_last | output | 1 | Final beat of the header |
| out_ready | input | 1 | Sink takes the beat |

## Verification
The hardest case to reach is a start that arrives while a header is still draining. It is worst when that start lands on the very edge that hands over a beat, because an acceptance there would overwrite the cell in flight. The stimulus stalls the sink, then raises start with different fields on the same edge as a handshake. The bench then checks that the remaining beats still carry the first cell and that `out_valid` falls after its last beat. The computed check is compared against a polynomial long-division model on all four layout and width combinations.

// File: rtl/atm_hdr_pkg.sv
package atm_hdr_pkg;
  localparam int OCT_W   = 8;
  localparam int HDR_OCT = 4;
  localparam int GFC_W   = 4;
  localparam int VPI_W   = 12;
  localparam int VCI_W   = 16;
  localparam int PTI_W   = 3;

  typedef logic [OCT_W-1:0] octet_t;
  typedef logic [HDR_OCT-1:0][OCT_W-1:0] hdr_oct_t;

  typedef struct packed {
    logic [GFC_W-1:0] gfc;
    logic [VPI_W-1:0] vpi;
    logic [VCI_W-1:0] vci;
    logic [PTI_W-1:0] pti;
    logic             clp;
  } hdr_fields_t;
endpackage

// File: rtl/atm_hdr_pack.sv
module atm_hdr_pack
  import atm_hdr_pkg::*;
(
  input  hdr_fields_t fld,
  input  logic        nni,
  output hdr_oct_t    octs
);
  localparam int VPI_LO = 8;

  logic [OCT_W-1:0] first_oct;

  generate
    if (VPI_W - 4 == OCT_W) begin : g_nni_full
      always_comb first_oct = nni ? fld.vpi[VPI_W-1:4]
                                  : {fld.gfc, fld.vpi[VPI_LO-1:4]};
    end else begin : g_nni_pad
      always_comb first_oct = nni ? fld.vpi[OCT_W+3:4]
                                  : {fld.gfc, fld.vpi[VPI_LO-1:4]};
    end
  endgenerate

  // octs[0] goes on the wire first
  always_comb begin
    octs[0] = first_oct;
    octs[1] = {fld.vpi[3:0], fld.vci[VCI_W-1:VCI_W-4]};
    octs[2] = fld.vci[VCI_W-5:4];
    octs[3] = {fld.vci[3:0], fld.pti, fld.clp};
  end
endmodule

// File: rtl/atm_hec_gen.sv
module atm_hec_gen
  import atm_hdr_pkg::*;
#(
  parameter logic [7:0] POLY  = 8'h07,
  parameter logic [7:0] COSET = 8'h55
) (
  input  hdr_oct_t octs,
  input  logic     calc,
  input  octet_t   prog,
  output octet_t   hec
);
  localparam int NBITS = HDR_OCT * OCT_W;

  octet_t crc;

  // one feedback step per header bit, most significant octet/bit first
  always_comb begin
    logic fb;
    crc = '0;
    for (int o = 0; o < HDR_OCT; o++) begin
      for (int b = OCT_W-1; b >= 0; b--) begin
        fb  = crc[OCT_W-1] ^ octs[o][b];
        crc = {crc[OCT_W-2:0], 1'b0};
        if (fb) crc = crc ^ POLY;
      end
    end
  end

  assign hec = calc ? (crc ^ COSET) : prog;

  initial assert (NBITS == 32) else $error("header width must be 32 bits");
endmodule

// File: rtl/atm_hdr_seq.sv
module atm_hdr_seq
  import atm_hdr_pkg::*;
#(
  parameter int DATA_W = 2 * OCT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wide,
  input  hdr_oct_t          octs,
  input  octet_t            hec,
  input  octet_t            udf,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last
);
  localparam int NBYTES       = HDR_OCT + 2;
  localparam int NARROW_BEATS = HDR_OCT + 1;
  localparam int WIDE_BEATS   = NBYTES / 2;
  localparam int IDX_W        = $clog2(NARROW_BEATS);

  typedef logic [NBYTES-1:0][OCT_W-1:0] bytes_t;

  bytes_t           bytes_q;
  logic             wide_q;
  logic [IDX_W-1:0] idx_q;
  bytes_t           bytes_in;

  function automatic logic [DATA_W-1:0] beat_of(bytes_t bv, logic w, logic [IDX_W-1:0] i);
    logic [DATA_W-1:0] d;
    if (w) d = {bv[2*i], bv[2*i+1]};
    else   d = {{(DATA_W-OCT_W){1'b0}}, bv[i]};
    return d;
  endfunction

  function automatic logic is_final(logic w, logic [IDX_W-1:0] i);
    return w ? (i == IDX_W'(WIDE_BEATS-1)) : (i == IDX_W'(NARROW_BEATS-1));
  endfunction

  always_comb begin
    for (int k = 0; k < HDR_OCT; k++) bytes_in[k] = octs[k];
    bytes_in[HDR_OCT]   = hec;
    bytes_in[HDR_OCT+1] = udf;
  end

  wire accept = start && !out_valid;
  wire take   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      idx_q     <= '0;
      wide_q    <= 1'b0;
      bytes_q   <= '0;
    end else if (accept) begin
      bytes_q   <= bytes_in;
      wide_q    <= wide;
      idx_q     <= '0;
      out_valid <= 1'b1;
      out_data  <= beat_of(bytes_in, wide, '0);
      out_last  <= 1'b0;
    end else if (take) begin
      if (out_last) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end else begin
        idx_q    <= idx_q + 1'b1;
        out_data <= beat_of(bytes_q, wide_q, idx_q + 1'b1);
        out_last <= is_final(wide_q, idx_q + 1'b1);
      end
    end
  end

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)) else $error("beat changed under stall"); // R9
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    start && !out_valid |=> out_valid && !out_last) else $error("start not accepted"); // R9
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid) else $error("last without valid"); // R10
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    take && out_last |=> !out_valid) else $error("valid after final beat"); // R10
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    out_valid && !wide_q |-> out_data[DATA_W-1:OCT_W] == '0) else $error("upper byte set in narrow mode"); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> idx_q < IDX_W'(wide_q ? WIDE_BEATS : NARROW_BEATS)) else $error("beat index out of range"); // R8
endmodule

// File: rtl/atm_hdr_asm.sv
module atm_hdr_asm
  import atm_hdr_pkg::*;
#(
  parameter logic [7:0] HEC_POLY  = 8'h07,
  parameter logic [7:0] HEC_COSET = 8'h55
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         nni_mode,
  input  logic         wide_mode,
  input  logic         hec_calc,
  input  logic [3:0]   gfc,
  input  logic [11:0]  vpi,
  input  logic [15:0]  vci,
  input  logic [2:0]   pti,
  input  logic         clp,
  input  logic [7:0]   hec_prog,
  input  logic [7:0]   udf2,
  output logic [15:0]  out_data,
  output logic         out_valid,
  output logic         out_last,
  input  logic         out_ready
);
  hdr_fields_t fld;
  hdr_oct_t    octs;
  octet_t      hec;

  assign fld = '{gfc: gfc, vpi: vpi, vci: vci, pti: pti, clp: clp};

  atm_hdr_pack u_pack (
    .fld  (fld),
    .nni  (nni_mode),
    .octs (octs)
  );

  atm_hec_gen #(.POLY(HEC_POLY), .COSET(HEC_COSET)) u_hec (
    .octs (octs),
    .calc (hec_calc),
    .prog (hec_prog),
    .hec  (hec)
  );

  atm_hdr_seq #(.DATA_W(16)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wide      (wide_mode),
    .octs      (octs),
    .hec       (hec),
    .udf       (udf2),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last)
  );
endmodule

// File: tb/atm_hdr_asm_bench.sv
module atm_hdr_asm_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, nni_mode = 1'b0, wide_mode = 1'b0, hec_calc = 1'b0;
  logic [3:0]  gfc = '0;
  logic [11:0] vpi = '0;
  logic [15:0] vci = '0;
  logic [2:0]  pti = '0;
  logic        clp = 1'b0;
  logic [7:0]  hec_prog = '0, udf2 = '0;
  logic [15:0] out_data;
  logic        out_valid, out_last;
  logic        out_ready = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  atm_hdr_asm u_atm_hdr_asm (
    .clk(clk), .rst(rst), .start(start), .nni_mode(nni_mode), .wide_mode(wide_mode),
    .hec_calc(hec_calc), .gfc(gfc), .vpi(vpi), .vci(vci), .pti(pti), .clp(clp),
    .hec_prog(hec_prog), .udf2(udf2), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last), .out_ready(out_ready)
  );

  typedef struct packed {
    logic nni; logic wide; logic hc;
    logic [3:0] g; logic [11:0] p; logic [15:0] c; logic [2:0] t; logic l;
    logic [7:0] hp; logic [7:0] u;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 4'hA, 12'hF5C, 16'h1234, 3'h5, 1'b1, 8'h99, 8'h3C},
    '{1'b1, 1'b0, 1'b1, 4'hA, 12'hF5C, 16'h1234, 3'h5, 1'b1, 8'h99, 8'h3C},
    '{1'b0, 1'b1, 1'b1, 4'h3, 12'h0E7, 16'hBEEF, 3'h2, 1'b0, 8'h11, 8'hC4},
    '{1'b1, 1'b1, 1'b1, 4'h3, 12'hABC, 16'h0F0F, 3'h7, 1'b1, 8'h22, 8'h5A},
    '{1'b0, 1'b0, 1'b0, 4'hF, 12'h123, 16'hFFFF, 3'h0, 1'b0, 8'hD7, 8'h81},
    '{1'b1, 1'b1, 1'b0, 4'h6, 12'hFFF, 16'h0000, 3'h1, 1'b1, 8'h6E, 8'hE6},
    '{1'b0, 1'b1, 1'b0, 4'h0, 12'h800, 16'h8001, 3'h4, 1'b0, 8'h00, 8'hFF},
    '{1'b1, 1'b0, 1'b1, 4'h9, 12'h001, 16'hFFFE, 3'h6, 1'b1, 8'hAB, 8'h00}
  };

  function automatic logic [31:0] model_hdr(vec_t v);
    logic [7:0] o1;
    o1 = v.nni ? v.p[11:4] : {v.g, v.p[7:4]};
    return {o1, v.p[3:0], v.c[15:12], v.c[11:4], v.c[3:0], v.t, v.l};
  endfunction

  function automatic logic [7:0] model_hec(vec_t v);
    logic [39:0] w;
    if (!v.hc) return v.hp;
    w = {model_hdr(v), 8'h00};
    for (int i = 39; i >= 8; i--)
      if (w[i]) w[i-:9] = w[i-:9] ^ 9'h107;
    return w[7:0] ^ 8'h55;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    nni_mode = v.nni; wide_mode = v.wide; hec_calc = v.hc;
    gfc = v.g; vpi = v.p; vci = v.c; pti = v.t; clp = v.l; hec_prog = v.hp; udf2 = v.u;
  endtask

  // stall: hold ready low on the first beat; poke: start with other fields mid-cell
  task automatic run_cell(input vec_t v, input bit stall, input bit poke);
    logic [31:0] h;
    logic [7:0]  hc;
    logic [15:0] exp [5];
    int nb;
    h  = model_hdr(v);
    hc = model_hec(v);
    if (v.wide) begin
      nb = 3;
      exp[0] = h[31:16]; exp[1] = h[15:0]; exp[2] = {hc, v.u};
    end else begin
      nb = 5;
      exp[0] = {8'h0, h[31:24]}; exp[1] = {8'h0, h[23:16]};
      exp[2] = {8'h0, h[15:8]};  exp[3] = {8'h0, h[7:0]}; exp[4] = {8'h0, hc};
    end
    @(negedge clk);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: scramble inputs after capture
    apply(~v);
    for (int b = 0; b < nb; b++) begin
      chk("R9 valid during beat", {15'h0, out_valid}, 16'h1);
      chk(v.wide ? "R8 wide beat (R2 R3 R4 R5 R6)" : "R7 narrow beat (R2 R3 R4 R5 R6)", out_data, exp[b]);
      chk("R10 last flag", {15'h0, out_last}, {15'h0, b == nb-1});
      if (stall && b == 0) begin
        out_ready = 1'b0;
        repeat (2) begin
          @(negedge clk);
          chk("R9 held under stall", out_data, exp[0]);
        end
      end
      out_ready = 1'b1;
      if (poke && b == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    chk("R10 valid falls after last", {15'h0, out_valid}, 16'h0);
    out_ready = 1'b0;
    if (poke) begin
      @(negedge clk);
      chk("R11 start while busy ignored", {15'h0, out_valid}, 16'h0);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 50000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 50000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {15'h0, out_valid}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", {15'h0, out_valid}, 16'h0);
    chk("R1 last after reset", {15'h0, out_last}, 16'h0);

    for (int i = 0; i < NV; i++) run_cell(VECS[i], i[0], 1'b0);

    // R5: idle-cell header 00 00 00 01 gives check 0x52
    d = '{1'b0, 1'b0, 1'b1, 4'h0, 12'h000, 16'h0000, 3'h0, 1'b1, 8'h00, 8'h00};
    chk("R5 idle cell model", {8'h0, model_hec(d)}, 16'h0052);
    run_cell(d, 1'b0, 1'b0);
    // R5: all-zero header gives 0x55
    d.l = 1'b0;
    run_cell(d, 1'b0, 1'b0);

    // R2: upper path bits ignored in user-network layout
    d = VECS[0]; d.p[11:8] = ~d.p[11:8];
    run_cell(d, 1'b0, 1'b0);
    // R3: flow-control nibble ignored in network-network layout
    d = VECS[1]; d.g = ~d.g;
    run_cell(d, 1'b0, 1'b0);

    // R11: start pulsed on a handshake edge mid-cell, narrow and wide
    run_cell(VECS[0], 1'b1, 1'b1);
    run_cell(VECS[3], 1'b0, 1'b1);

    // R1: reset during a cell
    @(negedge clk);
    apply(VECS[2]); start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 valid cleared by mid-cell reset", {15'h0, out_valid}, 16'h0);
    chk("R1 last cleared by mid-cell reset", {15'h0, out_last}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule